// File: doc/BRIEF.md
# Regulator Fault Latch and Power-Good Supervisor

This block gathers the digitized protection flags of a multiphase voltage regulator controller. It keeps a set of fault latches, drives the soft-start discharge and error-amplifier pull-down requests, and produces the power-good indication. Every analog decision (comparators, thresholds, the soft-start ramp) happens outside the block and reaches it as a clean logic level, sampled on `clk`. A switching-cycle strobe paces the open-loop detector. That detector trips when the error amplifier stays saturated for a run of consecutive switching cycles.

There are six causes, each held in its own latch bit. The causes are: open loop, enable low, VID fault, over-voltage, open sense line and daisy-chain fault. The first three together form the master fault latch. A one-hot-per-cause status vector keeps the cause or causes of the first fault since reset.

Power-good is driven by a five-state machine:
- `ST_IDLE` is the single cycle after reset.
- `ST_RAMP` means soft start is in progress.
- `ST_SETTLE` means soft start is done and the block is waiting for the output to enter its window.
- `ST_GOOD` means regulating.
- `ST_FAULT` means a latch is set.

The transitions are:
- Any state goes to `ST_FAULT` when any latch is set.
- `ST_IDLE` goes to `ST_RAMP` when no latch is set.
- `ST_RAMP` goes to `ST_SETTLE` on soft-start done.
- `ST_SETTLE` goes to `ST_GOOD` when the output is in its window.
- `ST_GOOD` goes to `ST_SETTLE` when the output leaves its window.
- `ST_SETTLE` or `ST_GOOD` goes to `ST_RAMP` when soft-start done drops.
- `ST_FAULT` goes to `ST_RAMP` once every latch is clear.

Top module: `vr_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, all six latch bits, `fault_status` and the saturation count are zero, `pgood` is low, and the state machine sits in `ST_IDLE`.
- R2: When `ea_high` is high at eight consecutive `cyc_stb` clocks, with no clock in between where `ea_high` is low, the open-loop bit (bit 0 of the cause set) sets at the clock of the eighth strobe. `fault_latch` is high from then on until reset.
- R3: Any clock with `ea_high` low clears the saturation count. Seven strobes, then a low, then seven more strobes leave `fault_latch` low.
- R4: The enable bit (bit 1) follows `!en_ok` one clock later. `en_ok` low therefore sets `fault_latch`, and `en_ok` high clears this cause.
- R5: `vid_fault_in` high sets the VID bit (bit 2). The bit stays set while `en_ok` is high and clears only on a clock with `en_ok` low and `vid_fault_in` low.
- R6: `sense_open` raises `ea_pulldown` and `ss_discharge` in the same cycle, without waiting for a clock. It also sets the open-sense bit (bit 4), which keeps `ea_pulldown` high until reset.
- R7: `ov_flag` sets bit 3 and `chain_fault_in` sets bit 5. Both bits are held until reset, force `pgood` low, and do not raise `fault_latch`.
- R8: `ss_discharge` is high whenever any latch bit is set or `sense_open` is high.
- R9: `pgood` rises only in `ST_GOOD`, which is reached through `ST_RAMP` and then `ST_SETTLE`, and only with `ss_done` and `in_window` high.
- R10: `pgood` falls in the same cycle that `in_window` falls, and the state returns to `ST_SETTLE`.
- R11: `pgood` is low in every cycle in which any latch bit is set.
- R12: `fault_status` captures the cause set on the first clock at which any latch bit becomes set. It holds that value until reset (bit order: 0 open loop, 1 enable, 2 VID, 3 over-voltage, 4 open sense, 5 daisy chain).
- R13: From `ST_FAULT`, once every latch bit is clear, the machine restarts at `ST_RAMP` and can reach `ST_GOOD` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cyc_stb | input | 1 | One-clock pulse per switching cycle |
| ea_high | input | 1 | Error amplifier saturated high |
| en_ok | input | 1 | Enable above its threshold |
| ov_flag | input | 1 | Over-voltage comparator |
| sense_open | input | 1 | Open remote-sense detection |
| in_window | input | 1 | Output within its regulation window |
| ss_done | input | 1 | Soft start completed |
| vid_fault_in | input | 1 | Invalid VID code detected |
| chain_fault_in | input | 1 | Open phase daisy chain detected |
| fault_latch | output | 1 | Master fault latch (open loop, enable, VID) |
| ss_discharge | output | 1 | Request to discharge the soft-start ramp |
| ea_pulldown | output | 1 | Request to pull the error amplifier low |
| pgood | output | 1 | Power good |
| fault_status | output | 6 | First-fault cause vector |

## Verification
The bench targets the following corner cases:
- **Saturation count boundary.** A detector that is off by one trips after seven strobes or needs nine. A detector that fails to clear on a dropped flag trips on the split run of seven plus seven.
- **Enable and VID clearing.** A VID bit cleared by enable alone, or left uncleared after the enable is re-issued, leaves `fault_latch` in the wrong state. The same goes for an enable bit that latches permanently.
- **Same-cycle sense reaction.** A registered pull-down shows up one cycle late.
- **Sticky latches.** The over-voltage and chain bits must block `pgood` without touching `fault_latch`.
- **First-fault status.** The capture must freeze once set. A status that accumulates later causes shows extra bits.

// File: rtl/vrfs_pkg.sv
package vrfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_SETTLE,
        ST_GOOD,
        ST_FAULT
    } pg_state_e;

    localparam int NCAUSE  = 6;
    localparam int C_LOOP  = 0;
    localparam int C_EN    = 1;
    localparam int C_VID   = 2;
    localparam int C_OV    = 3;
    localparam int C_SENSE = 4;
    localparam int C_CHAIN = 5;

endpackage

// File: rtl/vrfs_sat_detect.sv
module vrfs_sat_detect #(
    parameter int SAT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic ea_high,
    output logic trip
);
    localparam int CW = $clog2(SAT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SAT_CYCLES - 1);
    localparam logic [CW-1:0] FULL = CW'(SAT_CYCLES);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!ea_high) begin
            run_cnt <= '0;
        end else if (cyc_stb && run_cnt != FULL) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    always_comb begin
        trip = ea_high && cyc_stb && (run_cnt == LAST);
    end
endmodule

// File: rtl/vrfs_latch_bank.sv
module vrfs_latch_bank
    import vrfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_ok,
    input  logic [NCAUSE-1:0] set_req,
    output logic [NCAUSE-1:0] cause_q,
    output logic [NCAUSE-1:0] first_q
);
    logic [NCAUSE-1:0] cause_nxt;

    for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
        if (i == C_EN) begin : g_level
            assign cause_nxt[i] = set_req[i];
        end else if (i == C_VID) begin : g_reissue
            assign cause_nxt[i] = en_ok ? (cause_q[i] | set_req[i]) : set_req[i];
        end else begin : g_sticky
            assign cause_nxt[i] = cause_q[i] | set_req[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            first_q <= '0;
        end else begin
            cause_q <= cause_nxt;
            if (first_q == '0) begin
                first_q <= cause_nxt;
            end
        end
    end
endmodule

// File: rtl/vrfs_pgood_fsm.sv
module vrfs_pgood_fsm
    import vrfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_latch,
    input  logic ss_done,
    input  logic in_window,
    output logic pgood
);
    pg_state_e state_q, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:   state_nxt = any_latch ? ST_FAULT : ST_RAMP;
            ST_RAMP: begin
                if (any_latch)    state_nxt = ST_FAULT;
                else if (ss_done) state_nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (any_latch)      state_nxt = ST_FAULT;
                else if (!ss_done)  state_nxt = ST_RAMP;
                else if (in_window) state_nxt = ST_GOOD;
            end
            ST_GOOD: begin
                if (any_latch)       state_nxt = ST_FAULT;
                else if (!ss_done)   state_nxt = ST_RAMP;
                else if (!in_window) state_nxt = ST_SETTLE;
            end
            ST_FAULT:  state_nxt = any_latch ? ST_FAULT : ST_RAMP;
            default:   state_nxt = ST_FAULT;
        endcase
    end

    always_comb begin
        pgood = (state_q == ST_GOOD) && !any_latch && ss_done && in_window;
    end
endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
    import vrfs_pkg::*;
#(
    parameter int SAT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              ea_high,
    input  logic              en_ok,
    input  logic              ov_flag,
    input  logic              sense_open,
    input  logic              in_window,
    input  logic              ss_done,
    input  logic              vid_fault_in,
    input  logic              chain_fault_in,
    output logic              fault_latch,
    output logic              ss_discharge,
    output logic              ea_pulldown,
    output logic              pgood,
    output logic [NCAUSE-1:0] fault_status
);
    logic              sat_trip;
    logic [NCAUSE-1:0] set_req;
    logic [NCAUSE-1:0] cause_q;
    logic              any_latch;

    vrfs_sat_detect #(.SAT_CYCLES(SAT_CYCLES)) u_sat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb),
        .ea_high (ea_high),
        .trip    (sat_trip)
    );

    always_comb begin
        set_req          = '0;
        set_req[C_LOOP]  = sat_trip;
        set_req[C_EN]    = !en_ok;
        set_req[C_VID]   = vid_fault_in;
        set_req[C_OV]    = ov_flag;
        set_req[C_SENSE] = sense_open;
        set_req[C_CHAIN] = chain_fault_in;
    end

    vrfs_latch_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_ok   (en_ok),
        .set_req (set_req),
        .cause_q (cause_q),
        .first_q (fault_status)
    );

    always_comb begin
        any_latch    = |cause_q;
        fault_latch  = cause_q[C_LOOP] | cause_q[C_EN] | cause_q[C_VID];
        ea_pulldown  = sense_open | cause_q[C_SENSE];
        ss_discharge = any_latch | sense_open;
    end

    vrfs_pgood_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_latch (any_latch),
        .ss_done   (ss_done),
        .in_window (in_window),
        .pgood     (pgood)
    );
endmodule

// File: rtl/vrfs_checker.sv
module vrfs_checker #(
    parameter int SAT_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_stb,
    input logic       ea_high,
    input logic       en_ok,
    input logic       ss_done,
    input logic       in_window,
    input logic       fault_latch,
    input logic       ea_pulldown,
    input logic       pgood,
    input logic [5:0] fault_status
);
    int run_len;
    logic eighth_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_len <= 0;
        else if (!ea_high)     run_len <= 0;
        else if (cyc_stb && run_len < SAT_CYCLES) run_len <= run_len + 1;
    end

    assign eighth_hit = ea_high && cyc_stb && (run_len == SAT_CYCLES - 1);

    p_sat_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eighth_hit |=> fault_latch);

    p_en_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ok |=> fault_latch);

    p_sense_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ea_pulldown |=> ea_pulldown);

    p_pgood_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> (ss_done && in_window));

    p_pgood_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latch |-> !pgood);

    p_status_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status != 6'd0) |=> $stable(fault_status));
endmodule

bind vr_fault_supervisor vrfs_checker #(.SAT_CYCLES(SAT_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_stb      (cyc_stb),
    .ea_high      (ea_high),
    .en_ok        (en_ok),
    .ss_done      (ss_done),
    .in_window    (in_window),
    .fault_latch  (fault_latch),
    .ea_pulldown  (ea_pulldown),
    .pgood        (pgood),
    .fault_status (fault_status)
);

// File: tb/sim_vr_fault_supervisor.sv
`timescale 1ns/1ps
module sim_vr_fault_supervisor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 0, ea_high = 0, en_ok = 1, ov_flag = 0, sense_open = 0;
    logic in_window = 0, ss_done = 0, vid_fault_in = 0, chain_fault_in = 0;
    logic fault_latch, ss_discharge, ea_pulldown, pgood;
    logic [5:0] fault_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    vr_fault_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ea_high(ea_high),
        .en_ok(en_ok), .ov_flag(ov_flag), .sense_open(sense_open),
        .in_window(in_window), .ss_done(ss_done), .vid_fault_in(vid_fault_in),
        .chain_fault_in(chain_fault_in), .fault_latch(fault_latch),
        .ss_discharge(ss_discharge), .ea_pulldown(ea_pulldown), .pgood(pgood),
        .fault_status(fault_status)
    );

    // Behavioural reference: cause bits, a queue of saturated strobes, a phase number
    bit m_c[6];
    bit [5:0] m_first;
    bit sat_q[$];
    int m_phase; // 0 idle 1 ramp 2 settle 3 good 4 fault

    function automatic bit m_any();
        return m_c[0] | m_c[1] | m_c[2] | m_c[3] | m_c[4] | m_c[5];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_c[k]) m_c[k] = 0;
            m_first = 0;
            sat_q.delete();
            m_phase = 0;
        end else begin
            bit old_any, tripped;
            bit [5:0] vec;
            old_any = m_any();
            tripped = 0;
            if (!ea_high) sat_q.delete();
            else if (cyc_stb) begin
                if (sat_q.size() == 7) tripped = 1;
                if (sat_q.size() < 8) sat_q.push_back(1'b1);
            end
            if (tripped) m_c[0] = 1;
            m_c[1] = !en_ok;
            if (!en_ok) m_c[2] = vid_fault_in; else if (vid_fault_in) m_c[2] = 1;
            if (ov_flag) m_c[3] = 1;
            if (sense_open) m_c[4] = 1;
            if (chain_fault_in) m_c[5] = 1;
            for (int k = 0; k < 6; k++) vec[k] = m_c[k];
            if (m_first == 0) m_first = vec;
            if (old_any) m_phase = 4;
            else case (m_phase)
                0, 4: m_phase = 1;
                1: if (ss_done) m_phase = 2;
                2: if (!ss_done) m_phase = 1; else if (in_window) m_phase = 3;
                3: if (!ss_done) m_phase = 1; else if (!in_window) m_phase = 2;
                default: m_phase = 4;
            endcase
        end
    end

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit any;
        bit [5:0] e_fl;
        any = m_any();
        e_fl = {m_c[5], m_c[4], m_c[3], m_c[2], m_c[1], m_c[0]};
        check_eq(cur_req, "model outputs",
            {fault_latch, ss_discharge, ea_pulldown, pgood, 2'b00, fault_status},
            {m_c[0] | m_c[1] | m_c[2], any | sense_open, sense_open | m_c[4],
             (m_phase == 3) && !any && ss_done && in_window, 2'b00, m_first});
        if (e_fl != 6'd0 && pgood) check_eq("R11", "pgood with latch", pgood, 1'b0);
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
            compare_all();
        end
    endtask

    task automatic strobes(int n);
        repeat (n) begin
            cyc_stb = 1; step(1);
            cyc_stb = 0; step(1);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        cyc_stb = 0; ea_high = 0; en_ok = 1; ov_flag = 0; sense_open = 0;
        in_window = 0; ss_done = 0; vid_fault_in = 0; chain_fault_in = 0;
        repeat (3) @(posedge clk);
        #1;
        check_eq("R1", "reset outputs",
                 {fault_latch, ea_pulldown, pgood, fault_status}, 9'd0);
        rst_n = 1;
    endtask

    task automatic bring_up();
        ss_done = 1; in_window = 1;
        step(4);
    endtask

    initial begin
        // R1 and R9: reset state, then staged power-up
        cur_req = "R1";
        do_reset();
        cur_req = "R9";
        step(4);
        check_eq("R9", "pgood before ss_done", pgood, 1'b0);
        ss_done = 1; step(3);
        check_eq("R9", "pgood before window", pgood, 1'b0);
        in_window = 1; step(3);
        check_eq("R9", "pgood regulating", pgood, 1'b1);

        // R10: window loss drops pgood in the same cycle
        cur_req = "R10";
        in_window = 0; #1;
        check_eq("R10", "pgood window lost", pgood, 1'b0);
        step(1);
        in_window = 1; step(3);
        check_eq("R10", "pgood recovered", pgood, 1'b1);

        // R3: interrupted saturation run
        cur_req = "R3";
        ea_high = 1; strobes(7);
        ea_high = 0; step(1);
        ea_high = 1; strobes(7);
        check_eq("R3", "no trip on split run", fault_latch, 1'b0);
        check_eq("R3", "pgood kept", pgood, 1'b1);

        // R2: eight consecutive strobes trip
        cur_req = "R2";
        ea_high = 0; step(1);
        ea_high = 1; strobes(7);
        check_eq("R2", "no trip at seven", fault_latch, 1'b0);
        cyc_stb = 1; step(1); cyc_stb = 0;
        check_eq("R2", "trip at eighth", fault_latch, 1'b1);
        ea_high = 0; step(5);
        check_eq("R2", "open loop sticky", fault_latch, 1'b1);
        check_eq("R12", "status open loop", fault_status, 6'b000001);
        check_eq("R11", "pgood low", pgood, 1'b0);

        // R4 and R13: enable cause and restart
        cur_req = "R4";
        do_reset();
        bring_up();
        en_ok = 0; step(2);
        check_eq("R4", "enable low sets fault", fault_latch, 1'b1);
        check_eq("R8", "discharge on fault", ss_discharge, 1'b1);
        en_ok = 1; step(1);
        check_eq("R4", "enable high clears", fault_latch, 1'b0);
        cur_req = "R13";
        step(4);
        check_eq("R13", "restart reaches good", pgood, 1'b1);
        check_eq("R12", "status kept enable", fault_status, 6'b000010);

        // R5: VID cause needs enable re-issue
        cur_req = "R5";
        vid_fault_in = 1; step(1);
        vid_fault_in = 0; step(3);
        check_eq("R5", "vid sticky", fault_latch, 1'b1);
        en_ok = 0; step(2);
        en_ok = 1; step(1);
        check_eq("R5", "vid cleared by reissue", fault_latch, 1'b0);
        step(4);

        // R6: open sense reacts without a clock and holds
        cur_req = "R6";
        do_reset();
        bring_up();
        sense_open = 1; #1;
        check_eq("R6", "pulldown same cycle", ea_pulldown, 1'b1);
        check_eq("R8", "discharge same cycle", ss_discharge, 1'b1);
        step(1);
        sense_open = 0; step(3);
        check_eq("R6", "pulldown held", ea_pulldown, 1'b1);
        check_eq("R6", "fault latch untouched", fault_latch, 1'b0);
        check_eq("R12", "status sense", fault_status, 6'b010000);

        // R7: over-voltage and chain latches
        cur_req = "R7";
        do_reset();
        bring_up();
        ov_flag = 1; step(1);
        ov_flag = 0; step(2);
        check_eq("R7", "ov drops pgood", pgood, 1'b0);
        check_eq("R7", "ov not master", fault_latch, 1'b0);
        chain_fault_in = 1; step(1);
        chain_fault_in = 0; step(3);
        check_eq("R8", "discharge held", ss_discharge, 1'b1);
        check_eq("R12", "status first only", fault_status, 6'b001000);

        cur_req = "R1";
        do_reset();
        step(1);
        check_eq("R1", "latches cleared", {fault_latch, ss_discharge, fault_status}, 8'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule